// File: doc/BRIEF.md
# Frame-Triggered Nibble Capture Engine

This block passively records the traffic on a 4-bit multiplexed address/data bus of the LPC kind. It never drives the bus and never uses the bus clock. It watches the active-low frame-start line. Once that line has been seen high and then low, the block counts cycles of its own fast system clock to decide when to sample the bus. It takes a fixed number of nibbles, spaced about one bus clock apart. A nominal 200 MHz system clock gives 5 ns per cycle.

The nibbles are packed most significant first into 32-bit words. The words go into an 8-entry receive queue, which a consumer drains with a valid/ready handshake. The timing is open loop: capture never waits for the consumer. A word that arrives when the queue is full is discarded, and a sticky flag records the loss. A strobe output rises around every sample point, so the sampling instants can be lined up against the bus on a logic analyser.

Top module: `frame_nibble_sniffer`

## Requirements
- R1: A capture is armed only after the synchronized frame line has been seen high. If the line is low from reset onward, no capture starts, no strobe appears and no word is produced.
- R2: Call edge N the system clock edge at which the frame line is first low. The first nibble is the bus value present at edge N+4.
- R3: Each capture takes 16 nibbles, at edges N+4+6k for k = 0..15.
- R4: Nibbles are packed 8 per 32-bit word, the earliest nibble in bits [31:28] and the eighth in bits [3:0]. The first word holds nibbles 0..7 and the second holds nibbles 8..15.
- R5: After the 16th nibble, one more word is emitted holding the leftover accumulator contents, which is all zeros. Each capture therefore yields exactly 3 words.
- R6: Changes on the frame line while a capture is running have no effect on timing or data. After a capture, a new capture needs the line to go high and then low again.
- R7: The debug strobe is high for 2 consecutive cycles out of every 6-cycle sample slot: in the cycles that follow edges N+4+6k and N+5+6k. It is low at all other times.
- R8: Words leave in capture order on `word_o` while `valid_o` is high. The queue holds up to 8 words. A word shown with `ready_i` low stays unchanged until it is accepted.
- R9: A word produced while the queue is full is dropped and `overflow_o` goes high. The flag then stays high until reset. Capture timing never stalls.
- R10: Synchronous active-high reset empties the queue, clears the overflow flag and any capture in progress, and returns the engine to waiting for the frame line to go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock (nominally 200 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| frame_n_i | input | 1 | Asynchronous active-low frame-start line |
| bus_i | input | 4 | Asynchronous 4-bit bus being observed |
| strobe_o | output | 1 | Debug marker, high around each sample point |
| word_o | output | 32 | Head word of the receive queue |
| valid_o | output | 1 | Queue holds a word |
| ready_i | input | 1 | Consumer accepts the head word |
| overflow_o | output | 1 | Sticky flag for a word that was discarded |

## Verification
On every cycle, the checker confirms four things: each strobe pulse lasts exactly two cycles, a word held back by the consumer stays stable, the overflow flag is sticky and rises only when the queue is full, and reset clears the outputs. Several behaviours can only be shown by the bench scenarios, because they need knowledge of the stimulus. These are the sample instants measured from the frame edge, the nibble order inside each word, the trailing zero word, and immunity to frame glitches during a capture. The same holds for refusing to start while the line is already low, and for dropping exactly the ninth word when the consumer stalls.

// File: rtl/sniff_pkg.sv
package sniff_pkg;
   typedef enum logic [1:0] {
      ST_ARM   = 2'd0,
      ST_IDLE  = 2'd1,
      ST_RUN   = 2'd2,
      ST_FLUSH = 2'd3
   } sniff_state_e;

   function automatic int safe_clog2(input int v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction
endpackage

// File: rtl/sniff_sync.sv
module sniff_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg [STAGES];

   if (STAGES < 1) begin : g_bad_stages
      $error("sniff_sync: STAGES must be at least 1");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stg[0] <= '0;
            else     stg[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sniff_ctrl.sv
module sniff_ctrl
   import sniff_pkg::*;
#(
   parameter int NIB_W     = 4,
   parameter int WORD_W    = 32,
   parameter int NIBBLES   = 16,
   parameter int SPACING   = 6,
   parameter int START_DLY = 4,
   parameter int STROBE_HI = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_s_i,
   input  logic [NIB_W-1:0]  bus_s_i,
   output logic              push_o,
   output logic [WORD_W-1:0] push_data_o,
   output logic              strobe_o
);
   localparam int NPW  = WORD_W / NIB_W;
   localparam int PH_W = safe_clog2(SPACING);
   localparam int NC_W = safe_clog2(NIBBLES);
   localparam int FC_W = safe_clog2(NPW);
   localparam logic [PH_W-1:0] PH_LAST  = PH_W'(SPACING - 1);
   localparam logic [PH_W-1:0] PH_SHIFT = PH_W'(START_DLY - 1);
   localparam logic [PH_W-1:0] PH_STB0  = PH_W'(START_DLY - STROBE_HI);
   localparam logic [NC_W-1:0] NC_LAST  = NC_W'(NIBBLES - 1);
   localparam logic [FC_W-1:0] FC_LAST  = FC_W'(NPW - 1);

   if (WORD_W % NIB_W != 0) begin : g_bad_word
      $error("sniff_ctrl: WORD_W must be a multiple of NIB_W");
   end
   if (START_DLY < 1 || START_DLY > SPACING) begin : g_bad_dly
      $error("sniff_ctrl: START_DLY must lie in 1..SPACING");
   end
   if (STROBE_HI < 1 || STROBE_HI > START_DLY) begin : g_bad_stb
      $error("sniff_ctrl: STROBE_HI must lie in 1..START_DLY");
   end

   sniff_state_e      state;
   logic [PH_W-1:0]   phase;
   logic [NC_W-1:0]   nib_cnt;
   logic [FC_W-1:0]   fill;
   logic [WORD_W-1:0] acc;
   logic [WORD_W-1:0] acc_next;

   assign acc_next = {acc[WORD_W-NIB_W-1:0], bus_s_i};

   always_ff @(posedge clk) begin
      if (rst) begin
         state       <= ST_ARM;
         phase       <= '0;
         nib_cnt     <= '0;
         fill        <= '0;
         acc         <= '0;
         push_o      <= 1'b0;
         push_data_o <= '0;
      end else begin
         push_o <= 1'b0;
         case (state)
            ST_ARM: begin
               if (frame_s_i) state <= ST_IDLE;
            end
            ST_IDLE: begin
               if (!frame_s_i) begin
                  state   <= ST_RUN;
                  phase   <= '0;
                  nib_cnt <= '0;
                  fill    <= '0;
                  acc     <= '0;
               end
            end
            ST_RUN: begin
               phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
               if (phase == PH_SHIFT) begin
                  if (fill == FC_LAST) begin
                     push_o      <= 1'b1;
                     push_data_o <= acc_next;
                     acc         <= '0;
                     fill        <= '0;
                  end else begin
                     acc  <= acc_next;
                     fill <= fill + 1'b1;
                  end
                  if (nib_cnt == NC_LAST) state   <= ST_FLUSH;
                  else                    nib_cnt <= nib_cnt + 1'b1;
               end
            end
            ST_FLUSH: begin
               push_o      <= 1'b1;
               push_data_o <= acc;
               acc         <= '0;
               state       <= ST_ARM;
            end
            default: state <= ST_ARM;
         endcase
      end
   end

   assign strobe_o = (state == ST_RUN) && (phase >= PH_STB0) && (phase <= PH_SHIFT);
endmodule

// File: rtl/sniff_fifo.sv
module sniff_fifo
   import sniff_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] data_o,
   output logic             valid_o,
   input  logic             ready_i,
   output logic             full_o,
   output logic             ovf_o
);
   localparam int AW = safe_clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam bit POW2 = (DEPTH == (1 << AW));

   if (DEPTH < 2) begin : g_bad_depth
      $error("sniff_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    count;
   logic             do_wr, do_rd;

   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign full_o  = (count == CW'(DEPTH));
   assign valid_o = (count != '0);
   assign do_wr   = push_i && !full_o;
   assign do_rd   = valid_o && ready_i;
   assign data_o  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= data_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf_o  <= 1'b0;
      end else begin
         if (do_wr) wr_ptr <= wr_nxt;
         if (do_rd) rd_ptr <= rd_nxt;
         case ({do_wr, do_rd})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (push_i && full_o) ovf_o <= 1'b1;
      end
   end
endmodule

// File: rtl/frame_nibble_sniffer.sv
module frame_nibble_sniffer #(
   parameter int NIB_W      = 4,
   parameter int WORD_W     = 32,
   parameter int NIBBLES    = 16,
   parameter int SPACING    = 6,
   parameter int START_DLY  = 4,
   parameter int STROBE_HI  = 2,
   parameter int SYNC_STG   = 2,
   parameter int FIFO_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_n_i,
   input  logic [NIB_W-1:0]  bus_i,
   output logic              strobe_o,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o,
   input  logic              ready_i,
   output logic              overflow_o
);
   localparam int SYNC_W = NIB_W + 1;

   logic [SYNC_W-1:0] raw_in, sync_out;
   logic              frame_s;
   logic [NIB_W-1:0]  bus_s;
   logic              push;
   logic [WORD_W-1:0] push_data;
   logic              fifo_full;

   assign raw_in  = {frame_n_i, bus_i};
   assign frame_s = sync_out[SYNC_W-1];
   assign bus_s   = sync_out[NIB_W-1:0];

   sniff_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STG)) i_sync (
      .clk (clk),
      .rst (rst),
      .d_i (raw_in),
      .q_o (sync_out)
   );

   sniff_ctrl #(
      .NIB_W    (NIB_W),
      .WORD_W   (WORD_W),
      .NIBBLES  (NIBBLES),
      .SPACING  (SPACING),
      .START_DLY(START_DLY),
      .STROBE_HI(STROBE_HI)
   ) i_ctrl (
      .clk        (clk),
      .rst        (rst),
      .frame_s_i  (frame_s),
      .bus_s_i    (bus_s),
      .push_o     (push),
      .push_data_o(push_data),
      .strobe_o   (strobe_o)
   );

   sniff_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk    (clk),
      .rst    (rst),
      .push_i (push),
      .data_i (push_data),
      .data_o (word_o),
      .valid_o(valid_o),
      .ready_i(ready_i),
      .full_o (fifo_full),
      .ovf_o  (overflow_o)
   );
endmodule

// File: rtl/sniff_chk.sv
module sniff_chk #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              strobe_o,
   input logic [WORD_W-1:0] word_o,
   input logic              valid_o,
   input logic              ready_i,
   input logic              overflow_o,
   input logic              fifo_full
);
   // R7: a strobe pulse lasts at least two cycles
   assert_strobe_pair_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(strobe_o) |=> strobe_o);

   // R7: and no more than two
   assert_strobe_len_R7: assert property (@(posedge clk) disable iff (rst)
      (strobe_o && $past(strobe_o)) |=> !strobe_o);

   // R8: a word that has not been accepted stays put
   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (valid_o && !ready_i) |=> (valid_o && $stable(word_o)));

   // R9: the loss flag is sticky
   assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      overflow_o |=> overflow_o);

   // R9: a loss is only recorded while the queue is full
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(overflow_o) |-> $past(fifo_full));

   // R10: reset clears the visible state
   assert_reset_R10: assert property (@(posedge clk)
      rst |=> (!valid_o && !overflow_o && !strobe_o));
endmodule

bind frame_nibble_sniffer sniff_chk #(.WORD_W(WORD_W)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .strobe_o  (strobe_o),
   .word_o    (word_o),
   .valid_o   (valid_o),
   .ready_i   (ready_i),
   .overflow_o(overflow_o),
   .fifo_full (fifo_full)
);

// File: tb/test_frame_nibble_sniffer.sv
module test_frame_nibble_sniffer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        frame_n_i = 1'b0;
   logic [3:0]  bus_i = 4'h0;
   logic        ready_i = 1'b0;
   logic        strobe_o, valid_o, overflow_o;
   logic [31:0] word_o;

   int total = 0;
   int bad   = 0;
   logic [31:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_nibble_sniffer i_frame_nibble_sniffer (
      .clk       (clk),
      .rst       (rst),
      .frame_n_i (frame_n_i),
      .bus_i     (bus_i),
      .strobe_o  (strobe_o),
      .word_o    (word_o),
      .valid_o   (valid_o),
      .ready_i   (ready_i),
      .overflow_o(overflow_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every accepted word (R4, R5, R8)
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (!rst && valid_o && ready_i) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 unexpected word", word_o, 32'h0);
            end else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               chk(word_o === e, "R4 word content/order", word_o, e);
            end
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // driver: one capture; frame falls at negedge j=0 (edge N follows)
   task automatic run_frame(input logic [3:0] seed, input bit glitch);
      logic [3:0]  n [16];
      logic [31:0] w0, w1;
      int smis, pulses;
      bit prev;
      w0 = '0; w1 = '0; smis = 0; pulses = 0; prev = 1'b0;
      for (int k = 0; k < 16; k++) n[k] = seed + 4'(k * 5) + 4'(k / 3);
      for (int k = 0; k < 8; k++) begin
         w0 = {w0[27:0], n[k]};
         w1 = {w1[27:0], n[k+8]};
      end
      exp_q.push_back(w0);
      exp_q.push_back(w1);
      exp_q.push_back(32'h0);
      for (int j = 0; j < 106; j++) begin
         bit exp_s;
         @(negedge clk);
         if (j == 0)  frame_n_i = 1'b0;
         if (j == 20) frame_n_i = 1'b1;
         if (glitch && j == 40) frame_n_i = 1'b0;   // R6: ignored
         if (glitch && j == 45) frame_n_i = 1'b1;
         if (j >= 1 && j <= 96) bus_i = n[(j-1)/6];
         else                   bus_i = ~seed;
         exp_s = (j >= 5) && (j <= 96) && (((j - 5) % 6) < 2);
         if (strobe_o !== exp_s) smis++;
         if (strobe_o && !prev) pulses++;
         prev = strobe_o;
      end
      chk(smis == 0, "R7 strobe placement", 32'(smis), 32'h0);
      chk(pulses == 16, "R3 sample slot count", 32'(pulses), 32'd16);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int hits;
      idle(3);
      rst = 1'b0;
      @(negedge clk);
      chk(!valid_o && !overflow_o && !strobe_o, "R10 reset state",
          {29'h0, valid_o, overflow_o, strobe_o}, 32'h0);

      // R1: line low since reset must not start a capture
      hits = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         bus_i = 4'(i);
         if (strobe_o || valid_o) hits++;
      end
      chk(hits == 0, "R1 no capture while already low", 32'(hits), 32'h0);
      frame_n_i = 1'b1;
      ready_i = 1'b1;
      idle(6);

      // R2 R3 R4 R5: plain capture
      run_frame(4'h3, 1'b0);
      idle(10);
      chk(exp_q.size() == 0, "R5 three words per capture", 32'(exp_q.size()), 32'h0);
      chk(!valid_o, "R5 no extra word", {31'h0, valid_o}, 32'h0);

      // R6: frame glitch during capture
      run_frame(4'hA, 1'b1);
      idle(10);
      chk(exp_q.size() == 0, "R6 glitch ignored", 32'(exp_q.size()), 32'h0);

      // R10: reset in the middle of a capture
      @(negedge clk);
      frame_n_i = 1'b0;
      idle(30);
      rst = 1'b1;
      idle(2);
      rst = 1'b0;
      frame_n_i = 1'b1;
      @(negedge clk);
      chk(!valid_o && !strobe_o, "R10 mid-capture reset", {30'h0, valid_o, strobe_o}, 32'h0);
      idle(5);
      run_frame(4'h7, 1'b0);
      idle(10);
      chk(exp_q.size() == 0, "R10 recovery after reset", 32'(exp_q.size()), 32'h0);

      // R8 R9: stalled consumer
      ready_i = 1'b0;
      run_frame(4'h1, 1'b0);
      run_frame(4'h2, 1'b0);
      chk(!overflow_o, "R9 no loss at 6 words", {31'h0, overflow_o}, 32'h0);
      chk(valid_o === 1'b1, "R8 word waiting", {31'h0, valid_o}, 32'h1);
      run_frame(4'h5, 1'b0);
      void'(exp_q.pop_back());   // ninth word is lost
      chk(overflow_o === 1'b1, "R9 loss flagged", {31'h0, overflow_o}, 32'h1);
      ready_i = 1'b1;
      idle(20);
      chk(exp_q.size() == 0, "R8 eight words drained in order", 32'(exp_q.size()), 32'h0);
      chk(!valid_o, "R8 queue empty", {31'h0, valid_o}, 32'h0);
      chk(overflow_o === 1'b1, "R9 flag sticky", {31'h0, overflow_o}, 32'h1);

      rst = 1'b1;
      idle(2);
      rst = 1'b0;
      @(negedge clk);
      chk(!overflow_o, "R10 reset clears loss flag", {31'h0, overflow_o}, 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule